// File: doc/BRIEF.md
# Sampled-Set Replacement Policy Selector

This block picks one of two replacement policies, plain LRU or a cost-weighted policy, for every set of a cache. A sparse, fixed group of sampling sets acts as a test bed. In those sets the main tag directory always runs the cost-weighted policy. A small side directory, kept only for those sets, models LRU on the same accesses. Each access to a sampling set reports whether each of the two directories missed.

One global saturating counter tracks which directory misses less in the sampling sets. A miss seen only by the main directory moves the counter down. A miss seen only by the side directory moves it up. The top bit of the counter is registered and becomes the policy output. All other sets use that output and never train the counter.

The cache controller presents the set index of each access. The block flags whether that set is a sampling set, so the controller knows to consult the side directory. The controller then reports the two miss results in the same cycle, with a valid strobe. The tag arrays and the victim choice sit outside this block.

Top module: `duel_selector`

## Requirements
- R1: `is_leader` is combinational from `acc_set` alone, independent of `acc_valid`. With the default 1024 sets and 32 sampling sets, it is 1 exactly when `acc_set` modulo 32 equals the offset parameter (default 0): sets 0, 32, …, 992.
- R2: While `rst` is high and after its release, the 10-bit counter holds its midpoint 512. `policy` reads 1, the cost-weighted policy, until the counter's top bit changes.
- R3: A valid access to a sampling set with `main_miss`=1 and `aux_miss`=0 lowers the counter by one at the next clock edge.
- R4: A valid access to a sampling set with `aux_miss`=1 and `main_miss`=0 raises the counter by one at the next clock edge.
- R5: A valid sampling-set access with both miss flags set, or with neither set, leaves the counter unchanged.
- R6: An access to a non-sampling set, or any cycle with `acc_valid`=0, leaves the counter unchanged whatever the miss flags are.
- R7: The counter saturates at 1023 and never wraps to 0 on further increments.
- R8: The counter saturates at 0 and never wraps to 1023 on further decrements.
- R9: `policy` equals the counter's top bit as it stood one cycle earlier, with 1 = cost-weighted and 0 = LRU. It changes one clock after the top bit changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access with valid miss results is present this cycle |
| acc_set | input | 10 | Set index of the access |
| main_miss | input | 1 | Main directory missed on this access |
| aux_miss | input | 1 | Side LRU directory missed on this access |
| is_leader | output | 1 | Set index belongs to the sampling group |
| policy | output | 1 | Policy for all sets: 1 cost-weighted, 0 LRU |

## Verification
Two things can fall in the same cycle: a main-directory miss and a side-directory miss on one sampling-set access. The bench provokes this by raising both flags together, and judges that they cancel: the policy must not move over the following cycles. A second collision is a counter step in the same cycle that the policy register captures the previous top bit. This is provoked by walking the counter across 511/512, including at the end of long runs into saturation. The bench judges it by checking that the policy flips exactly one cycle after the step that moved the top bit, and at exactly the step count a non-wrapping counter predicts.

// File: rtl/duel_pkg.sv
package duel_pkg;
    parameter int NUM_SETS    = 1024;
    parameter int NUM_LEADERS = 32;
    parameter int CTR_W       = 10;
    parameter int LEADER_OFS  = 0;

    typedef enum logic {
        POL_LRU  = 1'b0,
        POL_COST = 1'b1
    } policy_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    function automatic step_e classify(input logic valid, input logic leader,
                                       input logic mmiss, input logic amiss);
        step_e s;
        s = STEP_HOLD;
        if (valid && leader) begin
            if (mmiss && !amiss)
                s = STEP_DOWN;
            else if (amiss && !mmiss)
                s = STEP_UP;
        end
        return s;
    endfunction
endpackage

// File: rtl/leader_match.sv
module leader_match #(
    parameter int NUM_SETS    = duel_pkg::NUM_SETS,
    parameter int NUM_LEADERS = duel_pkg::NUM_LEADERS,
    parameter int LEADER_OFS  = duel_pkg::LEADER_OFS,
    localparam int SET_W      = $clog2(NUM_SETS)
) (
    input  logic [SET_W-1:0] set_idx,
    output logic             leader
);
    localparam int STRIDE = NUM_SETS / NUM_LEADERS;
    localparam int SEL_W  = $clog2(STRIDE);

    generate
        if (SEL_W == 0) begin : g_all
            assign leader = 1'b1;
        end else begin : g_mod
            assign leader = (set_idx[SEL_W-1:0] == SEL_W'(LEADER_OFS));
        end
    endgenerate
endmodule

// File: rtl/sat_counter.sv
module sat_counter
    import duel_pkg::*;
#(
    parameter int CTR_W = duel_pkg::CTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step,
    output logic [CTR_W-1:0] count
);
    localparam logic [CTR_W-1:0] MID  = {1'b1, {(CTR_W-1){1'b0}}};
    localparam logic [CTR_W-1:0] TOP  = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] ONE  = {{(CTR_W-1){1'b0}}, 1'b1};

    logic [CTR_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        unique case (step)
            STEP_UP:   if (cnt_q != TOP) cnt_d = cnt_q + ONE;
            STEP_DOWN: if (cnt_q != '0)  cnt_d = cnt_q - ONE;
            default:   cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= MID;
        else
            cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/policy_latch.sv
module policy_latch
    import duel_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    top_bit,
    output policy_e pol
);
    policy_e pol_q;

    always_ff @(posedge clk) begin
        if (rst)
            pol_q <= POL_COST;
        else
            pol_q <= top_bit ? POL_COST : POL_LRU;
    end

    assign pol = pol_q;
endmodule

// File: rtl/duel_selector.sv
module duel_selector
    import duel_pkg::*;
#(
    parameter int NUM_SETS    = duel_pkg::NUM_SETS,
    parameter int NUM_LEADERS = duel_pkg::NUM_LEADERS,
    parameter int LEADER_OFS  = duel_pkg::LEADER_OFS,
    parameter int CTR_W       = duel_pkg::CTR_W,
    localparam int SET_W      = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic             main_miss,
    input  logic             aux_miss,
    output logic             is_leader,
    output logic             policy
);
    logic             leader_w;
    step_e            step_w;
    logic [CTR_W-1:0] ctr_val;
    policy_e          pol_w;

    leader_match #(
        .NUM_SETS    (NUM_SETS),
        .NUM_LEADERS (NUM_LEADERS),
        .LEADER_OFS  (LEADER_OFS)
    ) u_match (
        .set_idx (acc_set),
        .leader  (leader_w)
    );

    assign step_w = classify(acc_valid, leader_w, main_miss, aux_miss);

    sat_counter #(.CTR_W(CTR_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .step  (step_w),
        .count (ctr_val)
    );

    policy_latch u_pol (
        .clk     (clk),
        .rst     (rst),
        .top_bit (ctr_val[CTR_W-1]),
        .pol     (pol_w)
    );

    assign is_leader = leader_w;
    assign policy    = pol_w;
endmodule

// File: rtl/duel_selector_chk.sv
module duel_selector_chk #(
    parameter int CTR_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic             is_leader,
    input logic             main_miss,
    input logic             aux_miss,
    input logic             policy,
    input logic [CTR_W-1:0] ctr
);
    localparam logic [CTR_W-1:0] TOP = {CTR_W{1'b1}};

    a_r9_policy_tracks_msb: assert property (@(posedge clk) disable iff (rst)
        policy == $past(ctr[CTR_W-1]));

    a_r6_follower_no_train: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid || !is_leader) |=> $stable(ctr));

    a_r5_both_miss_hold: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && is_leader && main_miss && aux_miss) |=> $stable(ctr));

    a_r3_main_miss_down: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && is_leader && main_miss && !aux_miss && ctr != '0)
        |=> ctr == CTR_W'($past(ctr) - 1'b1));

    a_r4_aux_miss_up: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && is_leader && aux_miss && !main_miss && ctr != TOP)
        |=> ctr == CTR_W'($past(ctr) + 1'b1));

    a_r7_no_wrap_top: assert property (@(posedge clk) disable iff (rst)
        (ctr == TOP) |=> ctr != '0);

    a_r8_no_wrap_bottom: assert property (@(posedge clk) disable iff (rst)
        (ctr == '0) |=> ctr != TOP);
endmodule

bind duel_selector duel_selector_chk #(.CTR_W(CTR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .is_leader (is_leader),
    .main_miss (main_miss),
    .aux_miss  (aux_miss),
    .policy    (policy),
    .ctr       (ctr_val)
);

// File: tb/sim_duel_selector.sv
`timescale 1ns/1ps
module sim_duel_selector;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 1'b0;
    logic [9:0] acc_set = '0;
    logic       main_miss = 1'b0;
    logic       aux_miss = 1'b0;
    logic       is_leader;
    logic       policy;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        bit    exp_pol;
        string req;
    } item_t;
    item_t exp_q[$];

    int model_ctr = 512;

    always #5 clk = ~clk;

    duel_selector u0 (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_set   (acc_set),
        .main_miss (main_miss),
        .aux_miss  (aux_miss),
        .is_leader (is_leader),
        .policy    (policy)
    );

    task automatic check(input bit got, input bit exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // driver: one access per cycle; pushes the policy expected after the next edge
    task automatic acc(input bit v, input int s, input bit mm, input bit am, input string req);
        bit lead;
        item_t it;
        @(negedge clk);
        acc_valid = v;
        acc_set   = 10'(s);
        main_miss = mm;
        aux_miss  = am;
        #1;
        lead = ((s % 32) == 0);
        check(is_leader, lead, "R1");
        it.exp_pol = (model_ctr >= 512);   // R9: registered top bit of the present count
        it.req     = req;
        exp_q.push_back(it);
        if (v && lead) begin
            if (mm && !am && model_ctr > 0)    model_ctr--;      // R3, R8
            if (am && !mm && model_ctr < 1023) model_ctr++;      // R4, R7
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                check(policy, it.exp_pol, it.req);
            end
        end
    end

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(policy, 1'b1, "R2");
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(policy, 1'b1, "R2");

        // R1 leader decode across several indices
        acc(0, 0, 0, 0, "R1");
        acc(0, 32, 0, 0, "R1");
        acc(0, 992, 0, 0, "R1");
        acc(0, 1, 0, 0, "R1");
        acc(0, 31, 0, 0, "R1");
        acc(0, 33, 0, 0, "R1");
        acc(0, 1023, 0, 0, "R1");
        acc(0, 512, 0, 0, "R1");

        // R3 then R4 across the 511/512 boundary
        acc(1, 64, 1, 0, "R3");
        acc(0, 0, 0, 0, "R9");
        acc(0, 0, 0, 0, "R9");
        acc(1, 96, 0, 1, "R4");
        acc(0, 0, 0, 0, "R9");
        acc(0, 0, 0, 0, "R9");
        acc(1, 0, 1, 0, "R3");

        // R5 both or neither miss leave count at 511
        for (int i = 0; i < 4; i++) acc(1, 128, 1, 1, "R5");
        acc(1, 128, 0, 0, "R5");
        acc(1, 160, 0, 1, "R5");   // back to 512 proves nothing moved before
        acc(0, 0, 0, 0, "R5");
        acc(0, 0, 0, 0, "R5");
        acc(1, 160, 1, 0, "R5");   // 511 again

        // R6 followers and invalid cycles do not train
        for (int i = 0; i < 20; i++) acc(1, 5 + i, 0, 1, "R6");
        for (int i = 0; i < 10; i++) acc(0, 0, 0, 1, "R6");
        acc(0, 0, 0, 0, "R6");
        acc(0, 0, 0, 0, "R6");

        // R7 saturate high, then 512 decrements needed to drop the top bit
        for (int i = 0; i < 600; i++) acc(1, 32 * (i % 32), 0, 1, "R7");
        for (int i = 0; i < 512; i++) acc(1, 224, 1, 0, "R7");
        acc(0, 0, 0, 0, "R7");
        acc(0, 0, 0, 0, "R7");

        // R8 saturate low, then 512 increments needed to set the top bit
        for (int i = 0; i < 600; i++) acc(1, 256, 1, 0, "R8");
        for (int i = 0; i < 512; i++) acc(1, 288, 0, 1, "R8");
        acc(0, 0, 0, 0, "R8");
        acc(0, 0, 0, 0, "R8");
        acc(0, 0, 0, 0, "R9");

        repeat (3) @(posedge clk);
        #3;
        finish_run();
    end
endmodule